// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Load Interface

This block is the digital front end of a two-channel 12-bit converter fed from an 8-bit processor bus. Each channel holds a staging word and a live output word. The staging word is written in two pieces, a low byte and a high nibble. Two address lines pick which piece is written while the select and write strobes are active. Writing to a staging word never disturbs the outputs. A separate transfer strobe copies both staging words into both live words at once, on its rising edge, whether or not the chip is selected.

The bus strobes are asynchronous to the system clock. Every input passes through a two-flop synchronizer, and edges are detected in the clock domain. A write happens once per low period of the write strobe, at its falling edge. The transfer strobe must stay low for a set number of clock cycles after a write ends. A transfer edge that arrives sooner is thrown away, and a sticky error flag is raised.

Top module: `dual_dac_loader`

## Requirements
- R1: After a synchronous active-low reset, both output words read 0x000 and `xfer_err` reads 0. Reset also clears both staging words.
- R2: A write stores data in a staging part picked by `addr`. Code 2'b00 stores `din[7:0]` as channel A bits [7:0]. Code 2'b01 stores `din[3:0]` as channel A bits [11:8]. Code 2'b10 stores `din[7:0]` as channel B bits [7:0]. Code 2'b11 stores `din[3:0]` as channel B bits [11:8]. `din[7:4]` is ignored for nibble writes.
- R3: While `sel_n` is high, a pulse on `wr_n` changes no staging part.
- R4: The output words change only on an accepted transfer edge. A write alone leaves `dac_a` and `dac_b` unchanged.
- R5: A rising edge on `xfer` copies both staging words into `dac_a` and `dac_b` in the same clock cycle. This works even while `sel_n` is high.
- R6: A write takes effect once per low period of `wr_n`, on its falling edge. Changing `din` while `wr_n` stays low does not rewrite the part.
- R7: Staging parts can be written in any order. Writing one part keeps the other part of the same word.
- R8: A rising edge on `xfer` is rejected if `xfer` has been low for fewer than `LOAD_GAP_MIN` synchronized cycles since the last write ended. On rejection the outputs are not updated and `xfer_err` is set.
- R9: `xfer_err` stays set until reset. Later transfers that meet the gap rule still update the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Staging part select |
| din | input | 8 | Bus data, right-justified |
| xfer | input | 1 | Transfer strobe, acts on its rising edge |
| dac_a | output | 12 | Channel A live word |
| dac_b | output | 12 | Channel B live word |
| xfer_err | output | 1 | Sticky early-transfer error |

## Verification
The assertions assume that `addr` and `din` are stable for the whole time `wr_n` is low. Under that assumption, the synchronized data that is sampled at the write edge is the data the bus intended. The stimulus always sets `addr`, `din` and `sel_n` one clock before it lowers `wr_n`, and holds them until after `wr_n` rises. The one exception is the deliberate mid-pulse data change used to exercise R6. The stimulus raises `xfer` either well past the gap window or, on purpose, in the same cycle the write ends. This keeps the result of the gap check clear-cut and avoids an edge that lands near the threshold.

// File: rtl/dacif_pkg.sv
// Shared widths and part-select encoding for the dual-channel load interface.
package dacif_pkg;
    localparam int BUS_W  = 8;
    localparam int HI_W   = 4;
    localparam int WORD_W = BUS_W + HI_W;
    localparam int NCH    = 2;

    // Staging part picked by the address lines; bit 1 is the channel, bit 0 the half.
    typedef enum logic [1:0] {
        SLOT_A_LO = 2'b00,
        SLOT_A_HI = 2'b01,
        SLOT_B_LO = 2'b10,
        SLOT_B_HI = 2'b11
    } slot_e;
endpackage

// File: rtl/strobe_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes the bits of the bundle are stable around the edges that matter.
module strobe_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the chain per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/input_bank.sv
// Staging words for every channel, split into a low byte and a high nibble.
// Assumes wr_stb is a one-cycle pulse aligned with slot and data.
module input_bank
    import dacif_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_stb,
    input  logic [1:0]                   slot,
    input  logic [BUS_W-1:0]             data,
    output logic [NCH-1:0][WORD_W-1:0]   word
);
    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            logic [BUS_W-1:0] lo_q;
            logic [HI_W-1:0]  hi_q;
            logic             hit;

            assign hit = wr_stb && (slot[1] == c[0]);

            // Load the low byte when this channel's low half is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) lo_q <= '0;
                else if (hit && !slot[0]) lo_q <= data;
            end

            // Load the high nibble from the right-justified bus bits.
            always_ff @(posedge clk) begin
                if (!rst_n) hi_q <= '0;
                else if (hit && slot[0]) hi_q <= data[HI_W-1:0];
            end

            assign word[c] = {hi_q, lo_q};
        end
    endgenerate
endmodule

// File: rtl/xfer_guard.sv
// Detects transfer-strobe rising edges and enforces a minimum low time
// after each write. Early edges are discarded and raise a sticky flag.
// Assumes all inputs are already synchronized to clk.
module xfer_guard #(
    parameter int GAP_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_active,
    input  logic xfer_s,
    output logic fire,
    output logic err
);
    localparam int GAP_W = $clog2(GAP_MIN + 1) + 1;
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(GAP_MIN);

    logic             xfer_d;
    logic             rise;
    logic [GAP_W-1:0] gap;
    logic             gap_ok;

    assign rise   = xfer_s && !xfer_d;
    assign gap_ok = (gap >= GAP_LIM);
    assign fire   = rise && gap_ok;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_d <= 1'b0;
        else xfer_d <= xfer_s;
    end

    // Count low-strobe cycles since the last write, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) gap <= GAP_LIM;
        else if (wr_active) gap <= '0;
        else if (!xfer_s && !gap_ok) gap <= gap + 1'b1;
    end

    // Latch an error for any early edge until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else if (rise && !gap_ok) err <= 1'b1;
    end
endmodule

// File: rtl/dual_dac_loader.sv
// Top level: synchronizes the bus strobes, writes the staging words on each
// qualified write falling edge, and copies both staging words into the live
// outputs on an accepted transfer edge.
// Assumes addr/din are stable while wr_n is low.
module dual_dac_loader
    import dacif_pkg::*;
#(
    parameter int LOAD_GAP_MIN = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [BUS_W-1:0]  din,
    input  logic              xfer,
    output logic [WORD_W-1:0] dac_a,
    output logic [WORD_W-1:0] dac_b,
    output logic              xfer_err
);
    localparam int CTL_W = 3;
    localparam int DAT_W = 2 + BUS_W;

    logic [CTL_W-1:0]          ctl_s;
    logic [DAT_W-1:0]          dat_s;
    logic                      sel_s, wr_s, xfer_s;
    logic [1:0]                addr_s;
    logic [BUS_W-1:0]          din_s;
    logic                      wr_d;
    logic                      wr_stb;
    logic                      wr_active;
    logic                      fire;
    logic [NCH-1:0][WORD_W-1:0] stage_w;
    logic [NCH-1:0][WORD_W-1:0] live_q;

    strobe_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({sel_n, wr_n, xfer}), .q(ctl_s)
    );

    strobe_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(dat_s)
    );

    assign {sel_s, wr_s, xfer_s} = ctl_s;
    assign {addr_s, din_s}       = dat_s;
    assign wr_active             = !sel_s && !wr_s;

    // Track the previous write level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_d <= 1'b1;
        else wr_d <= wr_s;
    end

    assign wr_stb = wr_d && !wr_s && !sel_s;

    input_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
        .slot(addr_s), .data(din_s), .word(stage_w)
    );

    xfer_guard #(.GAP_MIN(LOAD_GAP_MIN)) u_guard (
        .clk(clk), .rst_n(rst_n), .wr_active(wr_active),
        .xfer_s(xfer_s), .fire(fire), .err(xfer_err)
    );

    // Copy every staging word into its live word on an accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else if (fire) live_q <= stage_w;
    end

    assign dac_a = live_q[0];
    assign dac_b = live_q[1];
endmodule

// File: rtl/dac_loader_chk.sv
// Property checker for dual_dac_loader, attached with bind.
module dac_loader_chk
    import dacif_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sel_s,
    input logic                       wr_stb,
    input logic [1:0]                 addr_s,
    input logic [BUS_W-1:0]           din_s,
    input logic                       fire,
    input logic                       xfer_err,
    input logic [WORD_W-1:0]          dac_a,
    input logic [WORD_W-1:0]          dac_b,
    input logic [NCH-1:0][WORD_W-1:0] stage_w
);
    // R4: live words only move on an accepted transfer.
    p_hold_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(dac_a) && $stable(dac_b)));

    // R5: an accepted transfer copies both staging words together.
    p_copy_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (dac_a == $past(stage_w[0]) && dac_b == $past(stage_w[1])));

    // R9: the error flag never clears outside reset.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> xfer_err);

    // R3: with select inactive, staging words stay put.
    p_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> $stable(stage_w));

    // R2: a low-byte write to channel A lands in bits [7:0].
    p_a_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr_s == SLOT_A_LO) |=> (stage_w[0][BUS_W-1:0] == $past(din_s)));

    // R2: a high-nibble write to channel B lands in bits [11:8].
    p_b_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr_s == SLOT_B_HI) |=> (stage_w[1][WORD_W-1:BUS_W] == $past(din_s[HI_W-1:0])));
endmodule

bind dual_dac_loader dac_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .wr_stb(wr_stb),
    .addr_s(addr_s), .din_s(din_s), .fire(fire), .xfer_err(xfer_err),
    .dac_a(dac_a), .dac_b(dac_b), .stage_w(stage_w)
);

// File: tb/sim_dual_dac_loader.sv
module sim_dual_dac_loader;
    localparam int GAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  din = '0;
    logic        xfer = 1'b0;
    logic [11:0] dac_a, dac_b;
    logic        xfer_err;

    int n_checks = 0;
    int n_errs = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_dac_loader #(.LOAD_GAP_MIN(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
        .addr(addr), .din(din), .xfer(xfer),
        .dac_a(dac_a), .dac_b(dac_b), .xfer_err(xfer_err)
    );

    // {addr, din, expected A, expected B} after write then transfer (R2, R7)
    localparam logic [33:0] VEC [8] = '{
        {2'b00, 8'h5A, 12'h05A, 12'h000},
        {2'b01, 8'hF3, 12'h35A, 12'h000},
        {2'b11, 8'h0C, 12'h35A, 12'hC00},
        {2'b10, 8'hA7, 12'h35A, 12'hCA7},
        {2'b00, 8'hFF, 12'h3FF, 12'hCA7},
        {2'b01, 8'h0E, 12'hEFF, 12'hCA7},
        {2'b11, 8'hF0, 12'hEFF, 12'h0A7},
        {2'b10, 8'h00, 12'hEFF, 12'h000}
    };

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d, input logic s_n);
        addr = a; din = d; sel_n = s_n;
        cyc(1);
        wr_n = 1'b0;
        cyc(4);
        wr_n = 1'b1;
        cyc(1);
        sel_n = 1'b1;
    endtask

    task automatic do_xfer();
        cyc(GAP + 4);
        xfer = 1'b1;
        cyc(5);
        xfer = 1'b0;
        cyc(2);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 dac_a", dac_a, 12'h000);
        chk("R1 dac_b", dac_b, 12'h000);
        chk("R1 err", {11'b0, xfer_err}, 12'h000);

        for (int k = 0; k < 8; k++) begin
            do_write(VEC[k][33:32], VEC[k][31:24], 1'b0);
            do_xfer();
            chk("R2/R7/R5 dac_a", dac_a, VEC[k][23:12]);
            chk("R2/R7/R5 dac_b", dac_b, VEC[k][11:0]);
        end

        // R4: writes without a transfer leave outputs alone
        do_write(2'b00, 8'h12, 1'b0);
        do_write(2'b11, 8'h09, 1'b0);
        cyc(GAP + 8);
        chk("R4 dac_a", dac_a, 12'hEFF);
        chk("R4 dac_b", dac_b, 12'h000);
        do_xfer();
        chk("R5 dac_a", dac_a, 12'hE12);
        chk("R5 dac_b", dac_b, 12'h900);

        // R3: strobe with select inactive changes nothing
        do_write(2'b00, 8'h77, 1'b1);
        do_write(2'b10, 8'h66, 1'b1);
        do_xfer();
        chk("R3 dac_a", dac_a, 12'hE12);
        chk("R3 dac_b", dac_b, 12'h900);

        // R6: one write per low period, data change mid-pulse ignored
        addr = 2'b10; din = 8'h11; sel_n = 1'b0;
        cyc(1);
        wr_n = 1'b0;
        cyc(4);
        din = 8'h22;
        cyc(4);
        wr_n = 1'b1;
        cyc(1);
        sel_n = 1'b1;
        do_xfer();
        chk("R6 dac_b", dac_b, 12'h911);

        // R8: transfer edge right as the write ends is rejected
        addr = 2'b00; din = 8'h3C; sel_n = 1'b0;
        cyc(1);
        wr_n = 1'b0;
        cyc(4);
        wr_n = 1'b1;
        sel_n = 1'b1;
        xfer = 1'b1;
        cyc(6);
        chk("R8 dac_a", dac_a, 12'hE12);
        chk("R8 err", {11'b0, xfer_err}, 12'h001);
        xfer = 1'b0;
        cyc(2);

        // R9: flag sticks, a later well-spaced transfer still updates
        do_xfer();
        chk("R9 dac_a", dac_a, 12'hE3C);
        chk("R9 err", {11'b0, xfer_err}, 12'h001);

        // R1: reset clears flag, outputs and staging words
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 err after reset", {11'b0, xfer_err}, 12'h000);
        chk("R1 dac_a after reset", dac_a, 12'h000);
        do_xfer();
        chk("R1 staging cleared", dac_b, 12'h000);

        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 20000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule